// File: doc/BRIEF.md
# Full-Bridge Gate Interlock Controller

This synchronous controller sits between a modulator and the gate drivers of an H-bridge. Each of the two half-bridges (legs) has a low-side request and a high-side request. The controller turns these four requests into four gate-enable outputs. It blocks any combination that would short a leg. A high low-side request always wins over the high-side request. A global disable input and an undervoltage flag force every output off.

A turn-on edge reaches an output only after its request has been present for a programmable number of clock edges. The high-side outputs share one delay setting and the low-side outputs share another. Turn-off is never delayed: an output drops in the same cycle its request or permission drops. When a leg's high-side request is simply tied high, its low-side request alone drives the leg as a complementary pair, with dead time inserted on each turn-on.

When the block comes out of disable or undervoltage, including the first release after reset, it runs a fixed sequence. Both low-side outputs are forced on for a refresh interval, which recharges bootstrap supplies. The high side is permitted only after a separate enable delay, counted from the same release edge. All timing values are cycle counts taken from configuration inputs. The configuration is expected to change only while the block is blocked.

Top module: `fb_gate_interlock`

## Requirements
- R1: While `dis_i` is 1, all four outputs are 0 in that same cycle, whatever the other inputs are.
- R2: While `uv_i` is 1, all four outputs are 0 in that same cycle, whatever the other inputs are.
- R3: In a leg where `lo_req_i[k]` is 1, `hi_out_o[k]` is 0 in that same cycle, even when `hi_req_i[k]` is also 1.
- R4: `hi_out_o[k]` can be 1 only while `lo_req_i[k]`=0 and `hi_req_i[k]`=1. With both requests 0, both outputs of the leg are 0 (outside the refresh pulse).
- R5: An output's command is its request, qualified by the current permission. An output rises right after the (d+1)-th consecutive clock edge at which its command was sampled 1. Here d is `hi_dly_i` for high-side outputs and `lo_dly_i` for low-side outputs.
- R6: An output falls in the same cycle its command falls, with no added clock edge.
- R7: With `hi_req_i[k]` held at 1, toggling `lo_req_i[k]` alone gives complementary outputs on leg k, with the dead time of R5 before each turn-on.
- R8: Call the first clock edge at which both `dis_i` and `uv_i` are sampled 0 after a blocked period the release edge. Both low-side outputs are then 1 for exactly `refresh_len_i` cycles, starting right after that edge, regardless of the low-side requests.
- R9: The high side is permitted from the (`hi_en_dly_i`+1)-th edge after the release edge, and never while the refresh pulse is on. A high-side command starts counting its R5 delay only from that point.
- R10: A request that stays 1 for fewer consecutive edges than the R5 delay needs produces no output pulse.
- R11: The two legs are independent, apart from the shared disable, undervoltage, delay and sequence settings.
- R12: Reset leaves all outputs 0 and the block in the blocked state. The first release after reset runs the R8 and R9 sequence.
- R13: In no cycle are both outputs of one leg 1.
- R14: If a command falls while its turn-on delay is still counting, the pending turn-on is dropped. The count restarts from zero at the next rising command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dis_i | input | 1 | Global disable, 1 forces all outputs off |
| uv_i | input | 1 | Undervoltage flag, 1 forces all outputs off |
| lo_req_i | input | 2 | Low-side requests, bit k for leg k |
| hi_req_i | input | 2 | High-side requests, bit k for leg k |
| hi_dly_i | input | CNT_W | High-side turn-on delay in cycles |
| lo_dly_i | input | CNT_W | Low-side turn-on delay in cycles |
| refresh_len_i | input | CNT_W | Refresh pulse length in cycles |
| hi_en_dly_i | input | CNT_W | Edges from release to high-side permission, minus one |
| lo_out_o | output | 2 | Low-side gate enables |
| hi_out_o | output | 2 | High-side gate enables |

## Verification
The outputs mix registered state with the present inputs. Blocking and turn-off therefore show in the same cycle as the input change. A turn-on shows right after the (d+1)-th edge of a steady command. The refresh pulse starts right after the release edge, and high-side permission comes hi_en_dly_i+1 edges after it. The bench drives inputs just after the falling clock edge and compares all four outputs a few nanoseconds later, in the same cycle. It computes the expected values from the current inputs plus a model of edge-counted request streaks and of the release sequence. The model state advances only at rising edges, so each of these latencies is checked in the exact cycle it is due.

// File: rtl/fbgi_pkg.sv
package fbgi_pkg;
  typedef enum logic [1:0] {
    SEQ_BLOCK   = 2'd0,
    SEQ_RELEASE = 2'd1,
    SEQ_ACTIVE  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fbgi_release_seq.sv
module fbgi_release_seq
  import fbgi_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             block_i,
  input  logic [CNT_W-1:0] refresh_len_i,
  input  logic [CNT_W-1:0] hi_en_dly_i,
  output logic             lo_allow_o,
  output logic             hi_allow_o,
  output logic             refresh_o
);
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_BLOCK: begin
        if (!block_i) begin
          state_d = SEQ_RELEASE;
          cnt_d   = '0;
        end
      end
      SEQ_RELEASE: begin
        if (block_i)                  state_d = SEQ_BLOCK;
        else if (cnt_q == hi_en_dly_i) state_d = SEQ_ACTIVE;
        else                          cnt_d   = cnt_q + 1'b1;
      end
      SEQ_ACTIVE: begin
        if (block_i) state_d = SEQ_BLOCK;
      end
      default: state_d = SEQ_BLOCK;
    endcase
  end

  assign cnt_en = (state_q == SEQ_RELEASE) || ((state_q == SEQ_BLOCK) && !block_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_BLOCK;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign lo_allow_o = (state_q != SEQ_BLOCK) && !block_i;
  assign hi_allow_o = (state_q == SEQ_ACTIVE) && !block_i;
  assign refresh_o  = (state_q == SEQ_RELEASE) && !block_i && (cnt_q < refresh_len_i);

  // R8: the refresh pulse only begins right after a release edge
  a_r8_refresh_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_o) |-> $past(state_q == SEQ_BLOCK));

  // R9: high-side permission only comes out of the release sequence
  a_r9_hi_from_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_allow_o) |-> $past(state_q == SEQ_RELEASE));

  // R12: a blocked cycle always returns the sequencer to the blocked state
  a_r12_block_returns: assert property (@(posedge clk) disable iff (!rst_n)
    block_i |=> (state_q == SEQ_BLOCK));
endmodule

// File: rtl/fbgi_turnon_delay.sv
module fbgi_turnon_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic             gate_o
);
  logic             on_q, on_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    on_d  = on_q;
    cnt_d = cnt_q;
    if (!cmd_i) begin
      on_d  = 1'b0;
      cnt_d = '0;
    end else if (!on_q) begin
      if (cnt_q == dly_i) on_d  = 1'b1;
      else                cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      on_q  <= on_d;
      cnt_q <= cnt_d;
    end
  end

  // Turn-off path is combinational so no edge is added to a falling command
  assign gate_o = on_q & cmd_i;

  // R5: a turn-on only follows a full count with the command present
  a_r5_rise_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_q) |-> ($past(cmd_i) && ($past(cnt_q) == $past(dly_i))));

  // R6: a low command clears the held turn-on at the next edge
  a_r6_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_i |=> !on_q);

  // R14: a dropped command restarts the count from zero
  a_r14_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_i |=> (cnt_q == '0));
endmodule

// File: rtl/fb_gate_interlock.sv
module fb_gate_interlock #(
  parameter int CNT_W  = 8,
  parameter int N_LEG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dis_i,
  input  logic             uv_i,
  input  logic [N_LEG-1:0] lo_req_i,
  input  logic [N_LEG-1:0] hi_req_i,
  input  logic [CNT_W-1:0] hi_dly_i,
  input  logic [CNT_W-1:0] lo_dly_i,
  input  logic [CNT_W-1:0] refresh_len_i,
  input  logic [CNT_W-1:0] hi_en_dly_i,
  output logic [N_LEG-1:0] lo_out_o,
  output logic [N_LEG-1:0] hi_out_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   block;
  logic                   lo_allow, hi_allow, refresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  assign block = dis_i | uv_i;

  fbgi_release_seq #(.CNT_W(CNT_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .block_i       (block),
    .refresh_len_i (refresh_len_i),
    .hi_en_dly_i   (hi_en_dly_i),
    .lo_allow_o    (lo_allow),
    .hi_allow_o    (hi_allow),
    .refresh_o     (refresh)
  );

  for (genvar g = 0; g < N_LEG; g++) begin : g_leg
    logic lo_cmd, hi_cmd, lo_gate, hi_gate;

    assign lo_cmd = lo_allow & lo_req_i[g];
    assign hi_cmd = hi_allow & hi_req_i[g] & ~lo_req_i[g];

    fbgi_turnon_delay #(.CNT_W(CNT_W)) u_lo_dly (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .cmd_i  (lo_cmd),
      .dly_i  (lo_dly_i),
      .gate_o (lo_gate)
    );

    fbgi_turnon_delay #(.CNT_W(CNT_W)) u_hi_dly (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .cmd_i  (hi_cmd),
      .dly_i  (hi_dly_i),
      .gate_o (hi_gate)
    );

    assign lo_out_o[g] = lo_gate | refresh;
    assign hi_out_o[g] = hi_gate;

    // R13: never both gates of one leg on
    a_r13_no_overlap: assert property (@(posedge clk) disable iff (!rst_int_n)
      !(lo_out_o[g] && hi_out_o[g]));

    // R3: a low-side request keeps the high gate off
    a_r3_lo_wins: assert property (@(posedge clk) disable iff (!rst_int_n)
      lo_req_i[g] |-> !hi_out_o[g]);

    // R1: disable forces the leg off
    a_r1_dis_off: assert property (@(posedge clk) disable iff (!rst_int_n)
      dis_i |-> !(lo_out_o[g] || hi_out_o[g]));

    // R2: undervoltage forces the leg off
    a_r2_uv_off: assert property (@(posedge clk) disable iff (!rst_int_n)
      uv_i |-> !(lo_out_o[g] || hi_out_o[g]));
  end
endmodule

// File: tb/tb_fb_gate_interlock.sv
module tb_fb_gate_interlock;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dis_i, uv_i;
  logic [1:0]    lo_req_i, hi_req_i;
  logic [CW-1:0] hi_dly_i, lo_dly_i, refresh_len_i, hi_en_dly_i;
  logic [1:0]    lo_out_o, hi_out_o;

  int n_cmp = 0;
  int n_bad = 0;
  string ptag;

  // model state: 0 blocked, 1 releasing, 2 active
  int m_st;
  int m_cnt;
  int s_lo[2];
  int s_hi[2];

  always #10 clk = ~clk;

  fb_gate_interlock #(.CNT_W(CW), .N_LEG(2)) dut (
    .clk(clk), .rst_n(rst_n), .dis_i(dis_i), .uv_i(uv_i),
    .lo_req_i(lo_req_i), .hi_req_i(hi_req_i),
    .hi_dly_i(hi_dly_i), .lo_dly_i(lo_dly_i),
    .refresh_len_i(refresh_len_i), .hi_en_dly_i(hi_en_dly_i),
    .lo_out_o(lo_out_o), .hi_out_o(hi_out_o)
  );

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got=%b expected=%b", tag, $time, got, exp);
    end
  endtask

  function automatic logic lo_cmd_f(int k);
    return (m_st != 0) && !(dis_i || uv_i) && lo_req_i[k];
  endfunction

  function automatic logic hi_cmd_f(int k);
    return (m_st == 2) && !(dis_i || uv_i) && hi_req_i[k] && !lo_req_i[k];
  endfunction

  // one cycle: inputs were set just after a falling edge
  task automatic cyc();
    logic [1:0] el, eh;
    logic       refr;
    #4;
    refr = (m_st == 1) && !(dis_i || uv_i) && (m_cnt < int'(refresh_len_i));
    for (int k = 0; k < 2; k++) begin
      el[k] = (lo_cmd_f(k) && (s_lo[k] > int'(lo_dly_i))) || refr;
      eh[k] = hi_cmd_f(k) && (s_hi[k] > int'(hi_dly_i));
    end
    if (!rst_n) begin
      el = 2'b00;
      eh = 2'b00;
    end
    check(ptag, {hi_out_o, lo_out_o}, {eh, el});
    check("R13", {2'b00, hi_out_o & lo_out_o}, 4'b0000);
    @(posedge clk);
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        s_lo[k] = lo_cmd_f(k) ? ((s_lo[k] < 1000) ? s_lo[k] + 1 : s_lo[k]) : 0;
        s_hi[k] = hi_cmd_f(k) ? ((s_hi[k] < 1000) ? s_hi[k] + 1 : s_hi[k]) : 0;
      end
      case (m_st)
        0: if (!(dis_i || uv_i)) begin m_st = 1; m_cnt = 0; end
        1: if (dis_i || uv_i) m_st = 0;
           else if (m_cnt == int'(hi_en_dly_i)) m_st = 2;
           else m_cnt++;
        default: if (dis_i || uv_i) m_st = 0;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4081));
    m_st = 0; m_cnt = 0;
    for (int k = 0; k < 2; k++) begin s_lo[k] = 0; s_hi[k] = 0; end
    rst_n = 1'b0; dis_i = 1'b1; uv_i = 1'b0;
    lo_req_i = 2'b11; hi_req_i = 2'b11;
    hi_dly_i = 8'd2; lo_dly_i = 8'd3; refresh_len_i = 8'd3; hi_en_dly_i = 8'd6;
    @(negedge clk);
    // R12: outputs off in reset
    ptag = "R12"; run(3);
    rst_n = 1'b1; run(4);
    // R8: release runs the refresh pulse with low requests idle
    dis_i = 1'b0; lo_req_i = 2'b00; hi_req_i = 2'b11;
    ptag = "R8"; run(4);
    // R9: high side waits for the enable delay, then its own dead time
    ptag = "R9"; run(16);
    // R3: both requests high, low wins
    lo_req_i = 2'b11; ptag = "R3"; run(10);
    // R4: both low, then only leg 0 high side
    lo_req_i = 2'b00; hi_req_i = 2'b00; ptag = "R4"; run(5);
    hi_req_i = 2'b01; run(8);
    // R5: low-side delay on leg 1
    lo_req_i = 2'b10; hi_req_i = 2'b00; ptag = "R5"; run(8);
    // R6: immediate turn-off
    lo_req_i = 2'b00; ptag = "R6"; run(2);
    // R7: bistate operation with high requests tied
    hi_req_i = 2'b11; ptag = "R7";
    for (int i = 0; i < 60; i++) begin
      lo_req_i[0] = ((i / 7) % 2) == 0;
      lo_req_i[1] = ((i / 5) % 2) == 1;
      cyc();
    end
    // R10: pulses shorter than the low-side delay
    hi_req_i = 2'b00; ptag = "R10";
    for (int i = 0; i < 24; i++) begin
      lo_req_i = ((i % 4) < 2) ? 2'b11 : 2'b00;
      cyc();
    end
    // R14: drop one cycle during counting, restart
    ptag = "R14";
    for (int i = 0; i < 24; i++) begin
      lo_req_i = ((i % 4) != 3) ? 2'b01 : 2'b00;
      cyc();
    end
    lo_req_i = 2'b01; run(6);
    // R11: leg 0 held, leg 1 random
    ptag = "R11"; hi_req_i = 2'b10;
    for (int i = 0; i < 40; i++) begin
      lo_req_i = {1'($urandom % 2), 1'b1};
      cyc();
    end
    // R1: disable pulses under random requests
    ptag = "R1";
    for (int i = 0; i < 80; i++) begin
      dis_i = ($urandom % 8) == 0;
      lo_req_i = 2'($urandom); hi_req_i = 2'($urandom);
      cyc();
    end
    // R2: undervoltage pulses under random requests
    dis_i = 1'b0; ptag = "R2";
    for (int i = 0; i < 80; i++) begin
      uv_i = ($urandom % 8) == 0;
      lo_req_i = 2'($urandom); hi_req_i = 2'($urandom);
      cyc();
    end
    uv_i = 1'b0;
    // random mix with new configuration taken while blocked
    ptag = "R5";
    for (int blk = 0; blk < 40; blk++) begin
      dis_i = 1'b1; run(1);
      hi_dly_i = 8'($urandom % 6); lo_dly_i = 8'($urandom % 6);
      refresh_len_i = 8'(1 + $urandom % 6);
      hi_en_dly_i = refresh_len_i + 8'($urandom % 6);
      run(1);
      dis_i = 1'b0;
      for (int i = 0; i < 50; i++) begin
        if (($urandom % 4) == 0) lo_req_i[0] = ~lo_req_i[0];
        if (($urandom % 4) == 0) lo_req_i[1] = ~lo_req_i[1];
        if (($urandom % 5) == 0) hi_req_i = 2'($urandom);
        uv_i = ($urandom % 64) == 0;
        cyc();
      end
      uv_i = 1'b0;
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule